// File: doc/BRIEF.md
# 32-bit SEC-DED Memory Word Guard

This block sits beside the data path of a 32-bit memory. Every full-word write leaves it carrying a freshly computed check word, stored with the data at the same address. Every read returns through it. The block recomputes the check word, forms a syndrome against the stored one, and replies with the word (repaired where that is safe) and two flags: a correctable error and a non-correctable error. A static input selects a 7-bit or an 8-bit check word. The parity-check columns are chosen so that a failed x1 or x4 memory device is always caught, and in 8-bit mode so is a failed x8 device. A second static input selects detect-only operation, in which no bit is ever altered.

Byte and halfword writes run as a read-modify-write sequence. The old word is read and checked, then latched. The enabled byte lanes of the new data are merged over the repaired old word, a new check word is computed, and the result is written back. If the read phase finds a non-correctable error, the write-back is abandoned and the error is returned.

The host side and the memory command side are valid/ready channels. A transfer happens on a rising edge where both valid and ready are high. An offered request or command holds its payload unchanged until it is taken. Only one host request is in flight at a time, so `req_ready` stays low from acceptance until the response has been taken. The memory read return has no ready signal: exactly one `mem_rd_valid` beat follows each accepted read command, and the block always accepts it.

Top module: `edac32_guard`

## Requirements
- R1: A request with `req_read`=0 and all four byte enables set issues one memory write carrying the data and its check word. A later read of that location with no stored bit disturbed returns the same data with `rsp_ce`=0 and `rsp_ue`=0.
- R2: When `cfg_wide_chk`=0, the check word is 7 bits in `mem_cmd_chk[6:0]`, `mem_cmd_chk[7]` is written as 0, and the value of `mem_rd_chk[7]` has no effect on any read result.
- R3: When exactly one of `mem_rd_data[31:0]` is inverted from what was written, the read returns the original word with `rsp_ce`=1 and `rsp_ue`=0.
- R4: When exactly one active check bit is inverted, the read returns the data unchanged with `rsp_ce`=1 and `rsp_ue`=0.
- R5: When exactly two of the active stored bits (data or check) are inverted, the read returns `rsp_ue`=1 and `rsp_ce`=0, with the data as it came from memory. The two flags are never both 1.
- R6: When `cfg_wide_chk`=0, any nonzero error pattern confined to one aligned nibble of data (bits 4n to 4n+3) sets at least one flag.
- R7: When `cfg_wide_chk`=1, any nonzero error pattern confined to one aligned data byte (bits 8n to 8n+7) sets at least one flag.
- R8: When `cfg_detect_only`=1, any error pattern with a nonzero syndrome, including any single-bit error, gives `rsp_ue`=1 and `rsp_ce`=0, with the data exactly as read.
- R9: A write with byte enables other than all ones reads the old word. Each lane b with `req_be[b]`=1 (bits 8b to 8b+7) is replaced by the new data, and the other lanes come from the repaired old word. The merged word is written with a new check word and is also returned in `rsp_data`. `rsp_ce` reports whether the read phase repaired a bit.
- R10: If the read phase of a partial write reports a non-correctable error, no memory write is issued. The response has `rsp_ue`=1, and `rsp_data` holds the old word as read.
- R11: A request or memory command that is held off by its ready signal keeps its payload. A response held by `rsp_ready`=0 stays valid and unchanged. `req_ready` is low while a request is in progress.
- R12: During and just after reset, `req_ready`=1, `rsp_valid`=0 and `mem_cmd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wide_chk | input | 1 | 1 selects the 8-bit check word, 0 the 7-bit one (static) |
| cfg_detect_only | input | 1 | 1 reports errors without altering data (static) |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Block can accept a request |
| req_read | input | 1 | 1 for a read, 0 for a write |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 4 | Byte-lane write enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 32 | Read word, or word written |
| rsp_ce | output | 1 | A single-bit error was repaired |
| rsp_ue | output | 1 | Non-correctable error |
| mem_cmd_valid | output | 1 | Memory command offered |
| mem_cmd_ready | input | 1 | Memory takes the command |
| mem_cmd_we | output | 1 | 1 for a write command |
| mem_cmd_addr | output | ADDR_W | Command address |
| mem_cmd_data | output | 32 | Data to store |
| mem_cmd_chk | output | 8 | Check word to store |
| mem_rd_valid | input | 1 | Read return beat |
| mem_rd_data | input | 32 | Stored data returned |
| mem_rd_chk | input | 8 | Stored check word returned |

## Verification
The bench sweeps every single-bit and every double-bit error over data and check bits in both check widths. A decoder that mistook a check-bit hit for a data-bit hit would corrupt clean data, and a column set with a duplicate or even-weight column would miscorrect a double error. Every nonzero pattern inside each nibble (7-bit mode) and each byte (8-bit mode) is injected, so an unlucky matrix that lets a device failure alias to a zero syndrome would return silently wrong data. Partial writes are run with every byte-enable mask. Each mask is run clean, with a repairable error, and with a non-repairable error: a sequencer that merged over the raw word would write the error back, and one that ignored the abort would overwrite the location. Detect-only mode, the unused eighth check bit in 7-bit mode, and stalls on both ready inputs round out the cases.

// File: rtl/edac_pkg.sv
`timescale 1ns/1ps
package edac_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CHK_W  = 8;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_CMD, ST_RD_WAIT, ST_MERGE, ST_WR_CMD, ST_RESP
  } rmw_state_e;

  // 7-bit code: nibble n gets an even-weight mask whose bits 6:4 equal n, so
  // every nibble sits in its own coset of the low-nibble pair space.
  function automatic logic [CHK_W-1:0] col_narrow(int unsigned i);
    logic [2:0] n;
    logic [3:0] lo;
    n = 3'(i / 4);
    if (^n)          lo = 4'h7;
    else if (n == 0) lo = 4'hF;
    else             lo = 4'h0;
    return {1'b0, n, lo} ^ (CHK_W'(1) << (i % 4));
  endfunction

  // 8-bit code: byte masks differ pairwise in at least four bits.
  function automatic logic [CHK_W-1:0] col_wide(int unsigned i);
    logic [CHK_W-1:0] m;
    case (i / 8)
      0:       m = 8'h0F;
      1:       m = 8'hF0;
      2:       m = 8'hFF;
      default: m = 8'h3C;
    endcase
    return m ^ (CHK_W'(1) << (i % 8));
  endfunction
endpackage

// File: rtl/edac_chkgen.sv
`timescale 1ns/1ps
module edac_chkgen
  import edac_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic              wide,
  output logic [CHK_W-1:0]  chk
);
  logic [CHK_W-1:0] term [DATA_W];

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [CHK_W-1:0] CN = col_narrow(i);
    localparam logic [CHK_W-1:0] CWD = col_wide(i);
    assign term[i] = data[i] ? (wide ? CWD : CN) : '0;
  end

  always_comb begin
    chk = '0;
    for (int i = 0; i < DATA_W; i++) chk ^= term[i];
  end
endmodule

// File: rtl/edac_decode.sv
`timescale 1ns/1ps
module edac_decode
  import edac_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  chk_in,
  input  logic              wide,
  input  logic              detect_only,
  output logic [DATA_W-1:0] dout,
  output logic              ce,
  output logic              ue,
  output logic [CHK_W-1:0]  syn
);
  logic [CHK_W-1:0]  regen, active;
  logic [DATA_W-1:0] hit;
  logic              odd, chk_only;

  edac_chkgen u_regen (.data(data), .wide(wide), .chk(regen));

  assign active = wide ? '1 : {1'b0, {(CHK_W-1){1'b1}}};
  assign syn    = (chk_in ^ regen) & active;

  for (genvar i = 0; i < DATA_W; i++) begin : g_hit
    localparam logic [CHK_W-1:0] CN = col_narrow(i);
    localparam logic [CHK_W-1:0] CWD = col_wide(i);
    assign hit[i] = (syn == (wide ? CWD : CN));
  end

  assign odd      = ^syn;
  assign chk_only = $onehot(syn);
  assign ce       = !detect_only && odd && ((|hit) || chk_only);
  assign ue       = (|syn) && !ce;
  assign dout     = ce ? (data ^ hit) : data;
endmodule

// File: rtl/edac_rmw_ctrl.sv
`timescale 1ns/1ps
module edac_rmw_ctrl
  import edac_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_ce,
  output logic              rsp_ue,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_we,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic [DATA_W-1:0] mem_cmd_data,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] dec_dout,
  input  logic              dec_ce,
  input  logic              dec_ue
);
  rmw_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q, word_q, merged;
  logic              read_q, ce_q, ue_q;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : word_q[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      word_q  <= '0;
      read_q  <= 1'b0;
      ce_q    <= 1'b0;
      ue_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          be_q    <= req_be;
          wdata_q <= req_wdata;
          read_q  <= req_read;
          ce_q    <= 1'b0;
          ue_q    <= 1'b0;
          if (!req_read && (&req_be)) begin
            word_q  <= req_wdata;
            state_q <= ST_WR_CMD;
          end else begin
            state_q <= ST_RD_CMD;
          end
        end
        ST_RD_CMD:  if (mem_cmd_ready) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rd_valid) begin
          word_q  <= dec_dout;
          ce_q    <= dec_ce;
          ue_q    <= dec_ue;
          state_q <= read_q ? ST_RESP : ST_MERGE;
        end
        ST_MERGE: begin
          if (ue_q) state_q <= ST_RESP;
          else begin
            word_q  <= merged;
            state_q <= ST_WR_CMD;
          end
        end
        ST_WR_CMD: if (mem_cmd_ready) state_q <= ST_RESP;
        ST_RESP:   if (rsp_ready) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_cmd_valid = (state_q == ST_RD_CMD) || (state_q == ST_WR_CMD);
  assign mem_cmd_we    = (state_q == ST_WR_CMD);
  assign mem_cmd_addr  = addr_q;
  assign mem_cmd_data  = word_q;
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_data      = word_q;
  assign rsp_ce        = ce_q;
  assign rsp_ue        = ue_q;

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_ce) && $stable(rsp_ue));
  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_we)
      && $stable(mem_cmd_data) && $stable(mem_cmd_addr));
  a_r10_no_write_on_ue: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && mem_cmd_we |-> !rsp_ue);
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_ce && rsp_ue));
endmodule

// File: rtl/edac32_guard.sv
`timescale 1ns/1ps
module edac32_guard
  import edac_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide_chk,
  input  logic              cfg_detect_only,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              rsp_ce,
  output logic              rsp_ue,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_we,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic [31:0]       mem_cmd_data,
  output logic [7:0]        mem_cmd_chk,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  input  logic [7:0]        mem_rd_chk
);
  logic [DATA_W-1:0] dec_dout;
  logic              dec_ce, dec_ue;
  logic [CHK_W-1:0]  dec_syn;

  edac_decode u_dec (
    .data(mem_rd_data), .chk_in(mem_rd_chk), .wide(cfg_wide_chk),
    .detect_only(cfg_detect_only), .dout(dec_dout), .ce(dec_ce),
    .ue(dec_ue), .syn(dec_syn)
  );

  edac_chkgen u_wgen (.data(mem_cmd_data), .wide(cfg_wide_chk), .chk(mem_cmd_chk));

  edac_rmw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_ce(rsp_ce), .rsp_ue(rsp_ue),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_we(mem_cmd_we), .mem_cmd_addr(mem_cmd_addr), .mem_cmd_data(mem_cmd_data),
    .mem_rd_valid(mem_rd_valid), .dec_dout(dec_dout), .dec_ce(dec_ce), .dec_ue(dec_ue)
  );

  a_r3_at_most_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> $countones(dec_dout ^ mem_rd_data) <= 1);
  a_r8_detect_only_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && cfg_detect_only |-> !dec_ce && (dec_dout == mem_rd_data));
  a_r1_clean_word: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && (dec_syn == '0) |-> !dec_ce && !dec_ue);
  a_r2_narrow_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && mem_cmd_we && !cfg_wide_chk |-> !mem_cmd_chk[7]);
endmodule

// File: tb/tb_edac32_guard.sv
`timescale 1ns/1ps
module tb_edac32_guard;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, cfg_wide = 1'b0, cfg_det = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0, rsp_ready = 1'b0, mem_cmd_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_be = '0;
  logic [31:0]   req_wdata = '0;
  logic req_ready, rsp_valid, rsp_ce, rsp_ue, mem_cmd_valid, mem_cmd_we;
  logic [31:0] rsp_data, mem_cmd_data;
  logic [AW-1:0] mem_cmd_addr;
  logic [7:0] mem_cmd_chk;
  logic mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic [7:0]  mem_rd_chk = '0;

  logic [39:0] store [16];
  logic [39:0] flip = '0;
  int wr_count = 0;
  logic [7:0] last_chk = '0;
  int n_tests = 0, n_fail = 0, cyc = 0;

  edac32_guard #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wide_chk(cfg_wide), .cfg_detect_only(cfg_det),
    .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_ce(rsp_ce), .rsp_ue(rsp_ue),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready), .mem_cmd_we(mem_cmd_we),
    .mem_cmd_addr(mem_cmd_addr), .mem_cmd_data(mem_cmd_data), .mem_cmd_chk(mem_cmd_chk),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .mem_rd_chk(mem_rd_chk)
  );

  // Memory model: one read beat the cycle after an accepted read command.
  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (rst_n && mem_cmd_valid && mem_cmd_ready) begin
      if (mem_cmd_we) begin
        store[mem_cmd_addr[3:0]] <= {mem_cmd_chk, mem_cmd_data};
        last_chk <= mem_cmd_chk;
        wr_count <= wr_count + 1;
      end else begin
        mem_rd_valid <= 1'b1;
        {mem_rd_chk, mem_rd_data} <= store[mem_cmd_addr[3:0]] ^ flip;
      end
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL R11 watchdog: actual hung, expected completion");
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input logic rd, input logic [3:0] be, input logic [AW-1:0] a,
                    input logic [31:0] wd, output logic [31:0] d, output logic ce, output logic ue);
    req_valid = 1'b1; req_read = rd; req_be = be; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data; ce = rsp_ce; ue = rsp_ue;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic wr_full(input logic [AW-1:0] a, input logic [31:0] wd);
    logic [31:0] d; logic ce, ue;
    op(1'b0, 4'hF, a, wd, d, ce, ue);
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a,
                        input logic [31:0] ed, input logic ece, input logic eue);
    logic [31:0] d; logic ce, ue;
    op(1'b1, 4'h0, a, 32'h0, d, ce, ue);
    chk(tag, {30'h0, ce, ue, d}, {30'h0, ece, eue, ed});
  endtask

  task automatic rd_flagged(input string tag, input logic [AW-1:0] a);
    logic [31:0] d; logic ce, ue;
    op(1'b1, 4'h0, a, 32'h0, d, ce, ue);
    chk(tag, 64'(ce | ue), 64'd1);
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  initial begin
    logic [31:0] pats [2];
    logic [31:0] d; logic ce, ue;
    int width, w0;
    pats[0] = 32'h8000_0001; pats[1] = 32'h3C5A_96E1;

    repeat (3) @(negedge clk);
    chk("R12 reset outputs", {61'h0, req_ready, rsp_valid, mem_cmd_valid}, 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 after reset", {61'h0, req_ready, rsp_valid, mem_cmd_valid}, 64'b100);

    for (int m = 0; m < 2; m++) begin
      cfg_wide = m[0];
      width = m ? 40 : 39;
      for (int p = 0; p < 2; p++) begin
        flip = '0;
        wr_full(8'd1, pats[p]);
        if (!cfg_wide) chk("R2 narrow chk[7] written 0", 64'(last_chk[7]), 64'd0);
        rd_chk("R1 clean readback", 8'd1, pats[p], 1'b0, 1'b0);
        if (!cfg_wide) begin
          flip = 40'h1 << 39;
          rd_chk("R2 narrow chk[7] ignored", 8'd1, pats[p], 1'b0, 1'b0);
        end
        for (int i = 0; i < width; i++) begin
          flip = 40'h1 << i;
          if (i < 32) rd_chk("R3 single data bit", 8'd1, pats[p], 1'b1, 1'b0);
          else        rd_chk("R4 single check bit", 8'd1, pats[p], 1'b1, 1'b0);
        end
        for (int i = 0; i < width; i++)
          for (int j = i + 1; j < width; j++) begin
            flip = (40'h1 << i) | (40'h1 << j);
            rd_chk("R5 double bit", 8'd1, pats[p] ^ flip[31:0], 1'b0, 1'b1);
          end
      end
      flip = '0;
      wr_full(8'd3, pats[1]);
      if (!cfg_wide) begin
        for (int n = 0; n < 8; n++)
          for (int v = 1; v < 16; v++) begin
            flip = 40'(v) << (4 * n);
            rd_flagged("R6 nibble device", 8'd3);
          end
      end else begin
        for (int n = 0; n < 4; n++)
          for (int v = 1; v < 256; v++) begin
            flip = 40'(v) << (8 * n);
            rd_flagged("R7 byte device", 8'd3);
          end
      end

      // detect-only mode
      cfg_det = 1'b1;
      for (int i = 0; i < width; i++) begin
        flip = 40'h1 << i;
        rd_chk("R8 detect-only single", 8'd3, pats[1] ^ flip[31:0], 1'b0, 1'b1);
      end
      flip = (40'h1 << 2) | (40'h1 << 33);
      rd_chk("R8 detect-only double", 8'd3, pats[1] ^ 32'h4, 1'b0, 1'b1);
      cfg_det = 1'b0;
    end

    // partial writes, every byte-enable mask
    for (int m = 0; m < 2; m++) begin
      cfg_wide = m[0];
      for (int be = 0; be < 15; be++) begin
        logic [31:0] bw, nw;
        bw = 32'h1357_9BDF; nw = 32'hE0F1_A2B3;
        flip = '0;
        wr_full(8'd5, bw);
        op(1'b0, 4'(be), 8'd5, nw, d, ce, ue);
        chk("R9 clean merge response", {30'h0, ce, ue, d}, {32'h0, merge(bw, nw, 4'(be))});
        rd_chk("R9 clean merge stored", 8'd5, merge(bw, nw, 4'(be)), 1'b0, 1'b0);

        wr_full(8'd5, bw);
        flip = 40'h1 << (3 + be);
        op(1'b0, 4'(be), 8'd5, nw, d, ce, ue);
        chk("R9 merge over repaired word", {30'h0, ce, ue, d}, {30'h0, 2'b10, merge(bw, nw, 4'(be))});
        flip = '0;
        rd_chk("R9 repaired merge stored", 8'd5, merge(bw, nw, 4'(be)), 1'b0, 1'b0);

        wr_full(8'd5, bw);
        flip = (40'h1 << be) | (40'h1 << (20 + be));
        w0 = wr_count;
        op(1'b0, 4'(be), 8'd5, nw, d, ce, ue);
        chk("R10 abort response", {30'h0, ce, ue, d}, {30'h0, 2'b01, bw ^ flip[31:0]});
        chk("R10 no write issued", 64'(wr_count - w0), 64'd0);
        rd_chk("R10 location untouched", 8'd5, bw ^ flip[31:0], 1'b0, 1'b1);
      end
    end

    // back-pressure on both channels
    flip = '0;
    wr_full(8'd7, 32'hCAFE_F00D);
    mem_cmd_ready = 1'b0;
    req_valid = 1'b1; req_read = 1'b1; req_addr = 8'd7; req_be = 4'h0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 command held under stall", {61'h0, mem_cmd_valid, mem_cmd_we, rsp_valid}, 64'b100);
    chk("R11 busy blocks requests", 64'(req_ready), 64'd0);
    chk("R11 command address held", 64'(mem_cmd_addr), 64'd7);
    mem_cmd_ready = 1'b1;
    while (!rsp_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R11 response held", {30'h0, rsp_valid, rsp_ue, rsp_data}, {30'h0, 2'b10, 32'hCAFE_F00D});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R11 response released", {62'h0, rsp_valid, req_ready}, 64'b01);

    summary();
    $finish;
  end
endmodule